// File: doc/BRIEF.md
# Test Verdict and Halt Port

This block is a write-only register slave for self-checking test programs running on a simulated or prototype system. A program halts the machine with a store to the halt register. It names the test that is running with a store of a memory pointer, and it reports the outcome with a store of a verdict word. A store of the pointer starts a master-side sequencer. The sequencer reads a fixed-length name string from system memory, one bus word at a time, into a local buffer. The buffer always ends with a zero byte.

The registers sit at word offsets inside a three-word window. The window starts at the `BASE` parameter, which defaults to 0xFFFF0000. Halt and verdict outcomes come out as single-cycle strobes. The verdict strobe carries the whole buffered name in parallel, so a monitor outside the block can log the result in that cycle. Any access the block refuses gives a one-cycle error strobe and changes nothing else.

Top module: `tvh_port`

## Requirements
- R1: Offsets from `BASE` select the register: 0 is halt, 4 is verdict, 8 is name pointer. Offset 12 and above is outside the window.
- R2: An access is taken only when `s_valid` and `s_ready` are both high. A taken access is honoured only if it is a write (`s_write`=1) of size code 2 (`s_size` holds log2 of the byte count, so 2 means 4 bytes). Reads and size codes 0, 1 and 3 are refused.
- R3: A taken access is also refused when `s_addr[1:0]` is non-zero or the address is outside the window. A refused access raises `s_err` for exactly one cycle, in the cycle after it is taken. It produces no halt, no verdict and no change to the stored pointer or name.
- R4: A write to the halt register with any data value raises `shutdown_o` for exactly one cycle, in the cycle after the write is taken.
- R5: A write to the verdict register raises `result_valid` for exactly one cycle, in the cycle after it is taken. In that cycle `result_code` equals the written data, `result_fail` is 1 exactly when the data is non-zero, and `dump_req` equals `result_fail`.
- R6: A write of pointer P to the name register starts 8 word reads on the master port, at P, P+4, …, P+28. Name byte 4i+j (held at `result_name[8*(4i+j) +: 8]`) is byte j, bits `[8j+7:8j]`, of the word read from P+4i.
- R7: After a fetch, name byte 31 is 0, whatever memory returned.
- R8: From the cycle after a name write until the cycle after the eighth read data arrives, `s_ready` is low and no access is taken. During that time `m_req` stays high, and `m_addr` stays stable until `m_rvalid` is seen.
- R9: Reset clears the stored pointer, the verdict and all pulse outputs, and sets all 32 name bytes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Slave access request |
| s_ready | output | 1 | Slave can take an access (low while the name fetch runs) |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | log2 of the access size in bytes |
| s_addr | input | 32 | Byte address |
| s_wdata | input | 32 | Write data |
| s_err | output | 1 | One-cycle strobe for a refused access |
| m_req | output | 1 | Master read request, held until data returns |
| m_addr | output | 32 | Master read address |
| m_rvalid | input | 1 | Master read data valid |
| m_rdata | input | 32 | Master read data |
| shutdown_o | output | 1 | One-cycle halt request |
| result_valid | output | 1 | One-cycle verdict strobe |
| result_fail | output | 1 | Verdict was non-zero |
| result_code | output | 32 | Last verdict word written |
| result_name | output | 256 | Buffered name, byte 0 in the low bits |
| dump_req | output | 1 | One-cycle state-dump request on a failing verdict |

## Verification
The assertions assume two things about the inputs. The memory returns `m_rvalid` only while `m_req` is high, and it returns one word per request. A bus master holds its access steady while `s_ready` is low. The bench memory model answers only a pending request, and its wait varies from zero to three cycles. The bench bus task holds the slave signals until the block takes the access. That keeps every run inside these assumptions, and it still drives every size code, direction and offset in and just outside the window.

// File: rtl/tvh_pkg.sv
package tvh_pkg;
   typedef enum logic [1:0] {
      SEL_HALT    = 2'd0,
      SEL_VERDICT = 2'd1,
      SEL_NAME    = 2'd2,
      SEL_NONE    = 2'd3
   } tvh_sel_e;

   localparam logic [1:0] SIZE_WORD = 2'd2;
   localparam int unsigned WIN_WORDS = 3;
endpackage

// File: rtl/tvh_decode.sv
module tvh_decode
   import tvh_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
   input  logic              write,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   output tvh_sel_e          sel
);
   localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(WIN_WORDS * 4);

   logic [ADDR_W-1:0] offset;
   logic              in_win, aligned, legal;

   always_comb begin
      offset  = addr - BASE;
      in_win  = offset < WIN_BYTES;
      aligned = addr[1:0] == 2'b00;
      legal   = write && (size == SIZE_WORD) && aligned && in_win;
      sel     = legal ? tvh_sel_e'(offset[3:2]) : SEL_NONE;
   end
endmodule

// File: rtl/tvh_fetch.sv
module tvh_fetch #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NAME_BYTES = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [ADDR_W-1:0]       ptr,
   output logic                    busy,
   output logic                    m_req,
   output logic [ADDR_W-1:0]       m_addr,
   input  logic                    m_rvalid,
   input  logic [DATA_W-1:0]       m_rdata,
   output logic [NAME_BYTES*8-1:0] name
);
   localparam int unsigned BPW   = DATA_W / 8;
   localparam int unsigned WORDS = NAME_BYTES / BPW;
   localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int unsigned BSH   = $clog2(BPW);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

   if ((DATA_W % 8) != 0 || (NAME_BYTES % BPW) != 0 || WORDS < 1) begin : g_bad_cfg
      $error("tvh_fetch: name length must be a whole number of bus words");
   end

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              take;

   assign take   = busy_q && m_rvalid;
   assign busy   = busy_q;
   assign m_req  = busy_q;
   assign m_addr = ptr_q + (ADDR_W'(idx_q) << BSH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         ptr_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         ptr_q  <= ptr;
      end else if (take) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST) busy_q <= 1'b0;
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic [DATA_W-1:0] next_word;
      if (w == WORDS - 1) begin : g_term
         assign next_word = {8'h00, m_rdata[DATA_W-9:0]};
      end else begin : g_plain
         assign next_word = m_rdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) word_q <= '0;
         else if (take && idx_q == IDX_W'(w)) word_q <= next_word;
      end
      assign name[w*DATA_W +: DATA_W] = word_q;
   end
endmodule

// File: rtl/tvh_port.sv
module tvh_port
   import tvh_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NAME_BYTES = 32,
   parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s_valid,
   output logic                    s_ready,
   input  logic                    s_write,
   input  logic [1:0]              s_size,
   input  logic [ADDR_W-1:0]       s_addr,
   input  logic [DATA_W-1:0]       s_wdata,
   output logic                    s_err,
   output logic                    m_req,
   output logic [ADDR_W-1:0]       m_addr,
   input  logic                    m_rvalid,
   input  logic [DATA_W-1:0]       m_rdata,
   output logic                    shutdown_o,
   output logic                    result_valid,
   output logic                    result_fail,
   output logic [DATA_W-1:0]       result_code,
   output logic [NAME_BYTES*8-1:0] result_name,
   output logic                    dump_req
);
   if (DATA_W != 32) begin : g_bad_width
      $error("tvh_port: the register slave is defined for 32-bit data");
   end
   if (BASE[3:0] != 4'h0) begin : g_bad_base
      $error("tvh_port: BASE must be aligned to 16 bytes");
   end

   tvh_sel_e sel;
   logic     busy, taken;

   assign s_ready = !busy;
   assign taken   = s_valid && s_ready;

   tvh_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .write (s_write),
      .size  (s_size),
      .addr  (s_addr),
      .sel   (sel)
   );

   tvh_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NAME_BYTES(NAME_BYTES)) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (taken && sel == SEL_NAME),
      .ptr      (s_wdata),
      .busy     (busy),
      .m_req    (m_req),
      .m_addr   (m_addr),
      .m_rvalid (m_rvalid),
      .m_rdata  (m_rdata),
      .name     (result_name)
   );

   logic              halt_q, res_q, fail_q, err_q;
   logic [DATA_W-1:0] verdict_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q    <= 1'b0;
         res_q     <= 1'b0;
         fail_q    <= 1'b0;
         err_q     <= 1'b0;
         verdict_q <= '0;
      end else begin
         halt_q <= taken && sel == SEL_HALT;
         res_q  <= taken && sel == SEL_VERDICT;
         err_q  <= taken && sel == SEL_NONE;
         if (taken && sel == SEL_VERDICT) begin
            verdict_q <= s_wdata;
            fail_q    <= |s_wdata;
         end
      end
   end

   assign shutdown_o   = halt_q;
   assign result_valid = res_q;
   assign result_fail  = fail_q;
   assign result_code  = verdict_q;
   assign dump_req     = res_q && fail_q;
   assign s_err        = err_q;
endmodule

// File: rtl/tvh_checker.sv
module tvh_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NAME_BYTES = 32,
   parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    s_valid,
   input logic                    s_ready,
   input logic                    s_write,
   input logic [1:0]              s_size,
   input logic [ADDR_W-1:0]       s_addr,
   input logic                    s_err,
   input logic                    m_req,
   input logic [ADDR_W-1:0]       m_addr,
   input logic                    m_rvalid,
   input logic                    shutdown_o,
   input logic                    result_valid,
   input logic                    result_fail,
   input logic [DATA_W-1:0]       result_code,
   input logic [NAME_BYTES*8-1:0] result_name,
   input logic                    dump_req
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_halt_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |-> past_ok && $past(s_valid && s_ready && s_write &&
                                      s_size == 2'd2 && s_addr == BASE));

   assert_dump_with_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dump_req |-> result_valid && result_fail);

   assert_fail_matches_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> result_fail == (result_code != '0));

   assert_name_terminated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> result_name[NAME_BYTES*8-1 -: 8] == 8'h00);

   assert_stall_fetching_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !s_ready |-> m_req);

   assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_req && !m_rvalid |=> $stable(m_addr));

   assert_err_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      s_err |-> !shutdown_o && !result_valid);
endmodule

bind tvh_port tvh_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NAME_BYTES(NAME_BYTES), .BASE(BASE)
) u_chk (.*);

// File: tb/sim_tvh_port.sv
module sim_tvh_port;
   localparam logic [31:0] BASE = 32'hFFFF_0000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         s_valid = 1'b0, s_write = 1'b0;
   logic [1:0]   s_size = 2'd0;
   logic [31:0]  s_addr = '0, s_wdata = '0;
   logic         s_ready, s_err, m_req, m_rvalid;
   logic [31:0]  m_addr, m_rdata, result_code;
   logic         shutdown_o, result_valid, result_fail, dump_req;
   logic [255:0] result_name;

   always #10 clk = ~clk;

   tvh_port u0 (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .s_write(s_write), .s_size(s_size), .s_addr(s_addr), .s_wdata(s_wdata),
      .s_err(s_err), .m_req(m_req), .m_addr(m_addr), .m_rvalid(m_rvalid),
      .m_rdata(m_rdata), .shutdown_o(shutdown_o), .result_valid(result_valid),
      .result_fail(result_fail), .result_code(result_code),
      .result_name(result_name), .dump_req(dump_req)
   );

   int checks = 0, fails = 0;
   int lat = 0, wait_cnt = 0, rd_count = 0;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
   endfunction

   function automatic logic [255:0] exp_name(input logic [31:0] p);
      logic [255:0] r;
      for (int i = 0; i < 8; i++) r[i*32 +: 32] = mem_word(p + 32'(4 * i));
      r[255:248] = 8'h00;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory responder: answers a pending request after lat idle cycles
   initial begin
      m_rvalid = 1'b0;
      m_rdata  = '0;
      forever begin
         @(negedge clk);
         if (m_rvalid) m_rvalid = 1'b0;
         else if (m_req) begin
            if (wait_cnt < lat) wait_cnt++;
            else begin
               m_rvalid = 1'b1;
               m_rdata  = mem_word(m_addr);
               wait_cnt = 0;
            end
         end
      end
   end

   always @(posedge clk) if (m_req && m_rvalid) rd_count++;

   logic c_shut, c_res, c_fail, c_dump, c_err, c_ready, c_after;
   logic [31:0]  c_code;
   logic [255:0] c_name;

   task automatic bus_acc(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz, input logic wr);
      @(negedge clk);
      s_valid = 1'b1; s_addr = a; s_wdata = d; s_size = sz; s_write = wr;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
      c_shut = shutdown_o; c_res = result_valid; c_fail = result_fail;
      c_dump = dump_req; c_err = s_err; c_code = result_code;
      c_name = result_name; c_ready = s_ready;
      @(negedge clk);
      c_after = shutdown_o | result_valid | s_err | dump_req;
      #1;
   endtask

   task automatic wait_idle();
      while (!s_ready) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] ptrs [3];
      logic [31:0] vals [3];
      logic [31:0] last_ptr;
      ptrs[0] = 32'h0000_1000; ptrs[1] = 32'h0002_0004; ptrs[2] = 32'h8000_00F0;
      vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h8000_0000;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(s_ready == 1'b1, "R9 ready", 256'(s_ready), 256'd1);
      chk({shutdown_o, result_valid, s_err, dump_req, m_req} == 5'b0, "R9 pulses idle",
          256'({shutdown_o, result_valid, s_err, dump_req, m_req}), 256'd0);
      chk(result_name == '0, "R9 name cleared", result_name, 256'd0);
      chk(result_code == '0, "R9 verdict cleared", 256'(result_code), 256'd0);

      // R5 pass verdict after reset carries an all-zero name (R9)
      bus_acc(BASE + 32'd4, 32'h0, 2'd2, 1'b1);
      chk(c_res && !c_fail && !c_dump && !c_err, "R5 pass verdict",
          256'({c_res, c_fail, c_dump, c_err}), 256'b1000);
      chk(c_name == '0, "R9 name after reset", c_name, 256'd0);
      chk(!c_after, "R5 strobe one cycle", 256'(c_after), 256'd0);

      // R4 halt with several data values
      foreach (vals[i]) begin
         bus_acc(BASE, vals[i] ^ 32'h1234_5678, 2'd2, 1'b1);
         chk(c_shut && !c_res && !c_err, "R4 halt pulse",
             256'({c_shut, c_res, c_err}), 256'b100);
         chk(!c_after, "R4 halt one cycle", 256'(c_after), 256'd0);
      end

      // R6 R7 R8 name fetch with varied memory latency
      foreach (ptrs[i]) begin
         int rd0;
         lat = i * 3 / 2;
         rd0 = rd_count;
         bus_acc(BASE + 32'd8, ptrs[i], 2'd2, 1'b1);
         chk(!c_ready, "R8 stall during fetch", 256'(c_ready), 256'd0);
         wait_idle();
         chk(rd_count - rd0 == 8, "R6 eight reads", 256'(rd_count - rd0), 256'd8);
         bus_acc(BASE + 32'd4, vals[i], 2'd2, 1'b1);
         chk(c_name == exp_name(ptrs[i]), "R6 R7 fetched name", c_name, exp_name(ptrs[i]));
         chk(c_res && c_fail == (vals[i] != 0) && c_dump == (vals[i] != 0),
             "R5 verdict flags", 256'({c_res, c_fail, c_dump}),
             256'({1'b1, vals[i] != 0, vals[i] != 0}));
         chk(c_code == vals[i], "R5 verdict code", 256'(c_code), 256'(vals[i]));
      end
      lat = 1;

      // R1 R2 R3 sweep of offsets, sizes and directions
      last_ptr = ptrs[2];
      for (int off = 0; off < 16; off++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int wr = 0; wr < 2; wr++) begin
               logic ok;
               logic [31:0] d;
               ok = (wr == 1) && (sz == 2) && (off % 4 == 0) && (off < 12);
               d = (off == 8) ? 32'h0000_3000 : 32'(off * 16 + sz * 2 + wr + 1);
               if (ok && off == 8) last_ptr = d;
               bus_acc(BASE + 32'(off), d, 2'(sz), 1'(wr));
               chk(c_err == !ok, "R2 R3 refusal", 256'(c_err), 256'(!ok));
               chk(c_shut == (ok && off == 0), "R1 halt decode", 256'(c_shut), 256'(ok && off == 0));
               chk(c_res == (ok && off == 4), "R1 verdict decode", 256'(c_res), 256'(ok && off == 4));
               if (ok && off == 4)
                  chk(c_code == d, "R5 sweep code", 256'(c_code), 256'(d));
               wait_idle();
            end
         end
      end

      // R3 addresses outside the window
      bus_acc(BASE - 32'd4, 32'h0000_5000, 2'd2, 1'b1);
      chk(c_err && !c_shut && !c_res, "R3 below base", 256'({c_err, c_shut, c_res}), 256'b100);
      bus_acc(BASE + 32'h108, 32'h0000_5000, 2'd2, 1'b1);
      chk(c_err && !c_ready == 1'b0, "R3 far offset", 256'({c_err, c_ready}), 256'b11);
      bus_acc(32'h0000_0008, 32'h0000_5000, 2'd2, 1'b1);
      chk(c_err, "R3 low address", 256'(c_err), 256'd1);
      bus_acc(BASE + 32'd9, 32'h0000_5000, 2'd2, 1'b1);
      chk(c_err && c_ready, "R3 misaligned no fetch", 256'({c_err, c_ready}), 256'b11);

      // R3 name unchanged by refused accesses
      bus_acc(BASE + 32'd4, 32'h0000_0007, 2'd2, 1'b1);
      chk(c_name == exp_name(last_ptr), "R3 name untouched", c_name, exp_name(last_ptr));
      chk(c_fail && c_dump, "R5 fail dump", 256'({c_fail, c_dump}), 256'b11);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule